// File: doc/BRIEF.md
# Partitioned SIMD Immediate Left Shifter

This block shifts every packed integer element of a 128-bit source vector left by one common amount. Elements are 8, 16, 32 or 64 bits wide. The lane width and the shift amount are both unpacked from a single 7-bit immediate field. Its top bit selects 64-bit lanes directly. Otherwise the position of the leading one in the six low bits sets the lane width, and the bits below it give the amount. One shifter spans the whole word, and a mask built for each bit clears every bit that would have come from a neighbouring lane. No bit therefore crosses a lane boundary.

A quad select picks the operand width. With it set, all 128 bits are processed. With it clear, only the low doubleword is processed and the upper half of the result is zero. Signed and unsigned data take the same path, and no condition flags are produced. An immediate in the reserved encoding raises an illegal flag and yields an all-zero result. The result is registered and appears one clock after the input strobe.

Top module: `simd_shl_imm`

## Requirements
- R1: With `in_imm[6]`=1 the lanes are 64 bits wide and the shift amount is `in_imm[5:0]` (0 to 63).
- R2: With `in_imm[6]`=0, lane width and amount are decoded from the low six bits. A pattern of 1xxxxx gives 32-bit lanes and shifts by the value minus 32. A pattern of 01xxxx gives 16-bit lanes and shifts by the value minus 16. A pattern of 001xxx gives 8-bit lanes and shifts by the value minus 8.
- R3: Bits shifted past the top of a lane are discarded, and the vacated low bits of each lane are zero. No bit moves from one lane into another.
- R4: Elements with their top bit set are treated exactly like other elements, with no sign extension or saturation.
- R5: The reserved immediate pattern 0000xxx sets `out_illegal` together with `out_valid`, and the result is all zeros.
- R6: With `in_quad`=0, only bits 63:0 are shifted and bits 127:64 of the result are zero. With `in_quad`=1, all 128 bits are shifted.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock, and the result of an operation is presented in that same cycle.
- R8: During synchronous active-high reset, `out_valid`, `out_illegal` and `out_vec` are all zero.
- R9: An amount of zero returns each processed element unchanged.
- R10: While `in_valid` is low, `out_vec` holds its last value and `out_illegal` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_vec | input | 128 | Source vector |
| in_imm | input | 7 | Packed lane-width and amount field, bit 6 selects 64-bit lanes |
| in_quad | input | 1 | 1: process 128 bits, 0: process the low 64 bits |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_vec | output | 128 | Shifted result vector |
| out_illegal | output | 1 | Reserved immediate seen for this result |

## Verification
Every result, including the illegal flag, is due on the first rising edge after the cycle in which `in_valid` was sampled high. Nothing else lies in the path. The bench drives inputs on falling edges and pushes the value it predicts into a queue. The monitor samples on the next falling edge, which falls half a period after the capturing edge. Whenever `out_valid` is high it pops one entry, so a result that comes a cycle early or late, or a missing or extra strobe, shows up as a mismatch or as a queue count that does not balance. Hold behaviour is checked over several idle falling edges after the last result.

// File: rtl/simd_shl_pkg.sv
package simd_shl_pkg;

    // lane width selected by the immediate field
    typedef enum logic [2:0] {
        LANE_B8   = 3'd0,
        LANE_B16  = 3'd1,
        LANE_B32  = 3'd2,
        LANE_B64  = 3'd3,
        LANE_NONE = 3'd4
    } lane_e;

    typedef struct packed {
        lane_e      lane;
        logic [5:0] amt;
        logic       illegal;
    } shl_ctl_t;

    function automatic int lane_bits(input lane_e l);
        case (l)
            LANE_B8:  return 8;
            LANE_B16: return 16;
            LANE_B32: return 32;
            LANE_B64: return 64;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/shl_imm_decode.sv
module shl_imm_decode
    import simd_shl_pkg::*;
(
    input  logic [6:0] imm_field,
    output shl_ctl_t   ctl
);

    always_comb begin
        ctl = '{lane: LANE_NONE, amt: 6'd0, illegal: 1'b1};
        unique casez (imm_field)
            7'b1??????: ctl = '{lane: LANE_B64, amt: imm_field[5:0],           illegal: 1'b0};
            7'b01?????: ctl = '{lane: LANE_B32, amt: {1'b0, imm_field[4:0]},  illegal: 1'b0};
            7'b001????: ctl = '{lane: LANE_B16, amt: {2'b0, imm_field[3:0]},  illegal: 1'b0};
            7'b0001???: ctl = '{lane: LANE_B8,  amt: {3'b0, imm_field[2:0]},  illegal: 1'b0};
            7'b0000???: ctl = '{lane: LANE_NONE, amt: 6'd0,                   illegal: 1'b1};
            default:    ctl = '{lane: LANE_NONE, amt: 6'd0,                   illegal: 1'b1};
        endcase
    end

    // decoded amount must stay inside the decoded lane
    always_comb begin
        if (!ctl.illegal) begin
            AST_AMT_IN_LANE: assert (int'(ctl.amt) < lane_bits(ctl.lane)); // R2
        end
    end

endmodule

// File: rtl/shl_lane_mask.sv
module shl_lane_mask
    import simd_shl_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  shl_ctl_t         ctl,
    output logic [VEC_W-1:0] keep
);

    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        localparam logic [6:0] POS8  = 7'(i % 8);
        localparam logic [6:0] POS16 = 7'(i % 16);
        localparam logic [6:0] POS32 = 7'(i % 32);
        localparam logic [6:0] POS64 = 7'(i % 64);
        logic bit_keep;

        always_comb begin
            case (ctl.lane)
                LANE_B8:  bit_keep = (POS8  >= {1'b0, ctl.amt});
                LANE_B16: bit_keep = (POS16 >= {1'b0, ctl.amt});
                LANE_B32: bit_keep = (POS32 >= {1'b0, ctl.amt});
                LANE_B64: bit_keep = (POS64 >= {1'b0, ctl.amt});
                default:  bit_keep = 1'b0;
            endcase
        end

        assign keep[i] = bit_keep;
    end

endmodule

// File: rtl/shl_barrel.sv
module shl_barrel #(
    parameter int VEC_W = 128,
    parameter int AMT_W = 6
) (
    input  logic [VEC_W-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [VEC_W-1:0] dout
);

    logic [VEC_W-1:0] stg [AMT_W+1];

    assign stg[0] = din;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
    end

    assign dout = stg[AMT_W];

endmodule

// File: rtl/simd_shl_imm.sv
module simd_shl_imm
    import simd_shl_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_vec,
    input  logic [6:0]       in_imm,
    input  logic             in_quad,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_illegal
);

    localparam int HALF_W = VEC_W / 2;
    localparam int AMT_W  = 6;

    shl_ctl_t         ctl;
    logic [VEC_W-1:0] operand;
    logic [VEC_W-1:0] shifted;
    logic [VEC_W-1:0] keep;
    logic [VEC_W-1:0] res_nxt;

    logic             valid_q;
    logic             ill_q;
    logic [VEC_W-1:0] vec_q;

    shl_imm_decode i_decode (
        .imm_field (in_imm),
        .ctl       (ctl)
    );

    assign operand = in_quad ? in_vec : {{HALF_W{1'b0}}, in_vec[HALF_W-1:0]};

    shl_barrel #(.VEC_W(VEC_W), .AMT_W(AMT_W)) i_barrel (
        .din  (operand),
        .amt  (ctl.amt),
        .dout (shifted)
    );

    shl_lane_mask #(.VEC_W(VEC_W)) i_mask (
        .ctl  (ctl),
        .keep (keep)
    );

    always_comb begin
        res_nxt = shifted & keep;
        if (!in_quad) begin
            res_nxt[VEC_W-1:HALF_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ill_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            valid_q <= in_valid;
            ill_q   <= in_valid & ctl.illegal;
            if (in_valid) begin
                vec_q <= res_nxt;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_illegal = ill_q;
    assign out_vec     = vec_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_vec == '0)); // R5
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_quad) |=> (out_vec[VEC_W-1:HALF_W] == '0)); // R6
    AST_LSB_VACATED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl.illegal && ctl.amt != '0) |=> !out_vec[0]); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && !out_illegal)); // R10
    AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_quad && in_imm == 7'b1000000) |=> (out_vec == $past(in_vec))); // R9

endmodule

// File: tb/test_simd_shl_imm.sv
module test_simd_shl_imm;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_vec;
    logic [6:0]   in_imm;
    logic         in_quad;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_illegal;

    always #2 clk = ~clk;

    simd_shl_imm i_simd_shl_imm (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_vec      (in_vec),
        .in_imm      (in_imm),
        .in_quad     (in_quad),
        .out_valid   (out_valid),
        .out_vec     (out_vec),
        .out_illegal (out_illegal)
    );

    typedef struct {
        logic [127:0] vec;
        bit           ill;
        string        req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // independent model: extract each lane, shift, mask, reinsert
    function automatic void ref_model(input logic [127:0] src, input logic [6:0] imm,
                                      input bit q, output logic [127:0] res, output bit ill);
        int          es;
        int          amt;
        int          lanes;
        logic [63:0] m;
        logic [63:0] elem;
        ill = 1'b0;
        es  = 0;
        amt = 0;
        res = '0;
        if (imm[6])      begin es = 64; amt = int'(imm[5:0]); end
        else if (imm[5]) begin es = 32; amt = int'(imm[4:0]); end
        else if (imm[4]) begin es = 16; amt = int'(imm[3:0]); end
        else if (imm[3]) begin es = 8;  amt = int'(imm[2:0]); end
        else ill = 1'b1;
        if (!ill) begin
            m     = (es == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << es) - 64'd1);
            lanes = (q ? 128 : 64) / es;
            for (int e = 0; e < lanes; e++) begin
                elem = 64'(src >> (e * es)) & m;
                elem = (elem << amt) & m;
                res  = res | (128'(elem) << (e * es));
            end
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [127:0] v, input logic [6:0] imm, input bit q, input string req);
        exp_t x;
        ref_model(v, imm, q, x.vec, x.ill);
        x.req = req;
        sb.push_back(x);
        in_valid = 1'b1;
        in_vec   = v;
        in_imm   = imm;
        in_quad  = q;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: result due one clock after the strobe
    always @(negedge clk) begin : mon
        exp_t x;
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected out_valid", 128'(out_valid), 128'd0);
            end else begin
                x = sb.pop_front();
                check(out_vec == x.vec, x.req, "out_vec", out_vec, x.vec);
                check(out_illegal == x.ill, x.req, "out_illegal", 128'(out_illegal), 128'(x.ill));
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic [127:0] held;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_vec   = {4{32'hDEAD_BEEF}};
        in_imm   = 7'h7F;
        in_quad  = 1'b1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(out_valid == 1'b0, "R8", "out_valid in reset", 128'(out_valid), 128'd0);
        check(out_illegal == 1'b0, "R8", "out_illegal in reset", 128'(out_illegal), 128'd0);
        check(out_vec == '0, "R8", "out_vec in reset", out_vec, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: 64-bit lanes
        send(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 7'b1000100, 1'b1, "R1");
        send(128'h8000_0000_0000_0001_0000_0000_0000_0003, 7'b1111111, 1'b1, "R1");
        // R2: 32, 16, 8-bit lanes
        send(128'h1111_2222_3333_4444_5555_6666_7777_8888, 7'b0100101, 1'b1, "R2");
        send(128'hF0F0_0F0F_1234_5678_9ABC_DEF0_AAAA_5555, 7'b0010011, 1'b1, "R2");
        send(128'h0102_0408_1020_4080_FF7F_3F1F_0F07_0301, 7'b0001111, 1'b1, "R2");
        // R3: all ones, bytes shift 3 -> F8 per byte, no carry between lanes
        send({128{1'b1}}, 7'b0001011, 1'b1, "R3");
        send({128{1'b1}}, 7'b0111111, 1'b1, "R3");
        // R4: top bit set, no sign fill
        send({8{16'h8080}}, 7'b0010001, 1'b1, "R4");
        send({16{8'hC3}}, 7'b0001001, 1'b1, "R4");
        // R5: reserved encoding right after a nonzero result
        send({4{32'h5A5A_A5A5}}, 7'b0000101, 1'b1, "R5");
        send({4{32'h5A5A_A5A5}}, 7'b0000000, 1'b0, "R5");
        // R6: doubleword only, and full width
        send(128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 7'b0100100, 1'b0, "R6");
        send(128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 7'b1000000, 1'b0, "R6");
        // R9: zero amount passes through
        send(128'hCAFE_BABE_0000_FFFF_1357_9BDF_2468_ACE0, 7'b1000000, 1'b1, "R9");
        send(128'hCAFE_BABE_0000_FFFF_1357_9BDF_2468_ACE0, 7'b0001000, 1'b1, "R9");
        send(128'hCAFE_BABE_0000_FFFF_1357_9BDF_2468_ACE0, 7'b0100000, 1'b0, "R9");

        // R10: hold while idle with changing inputs
        held     = out_vec;
        in_valid = 1'b0;
        in_vec   = ~in_vec;
        in_imm   = 7'b0000001;
        repeat (3) @(negedge clk);
        check(out_vec == held, "R10", "out_vec held", out_vec, held);
        check(out_illegal == 1'b0, "R10", "out_illegal idle", 128'(out_illegal), 128'd0);
        check(out_valid == 1'b0, "R7", "out_valid idle", 128'(out_valid), 128'd0);

        // sweep all immediates (R1, R2, R5, R6)
        for (int k = 0; k < 128; k++) begin
            send({$urandom, $urandom, $urandom, $urandom}, 7'(k), bit'($urandom & 1), "R2");
            if (k % 5 == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R7", "pending results", 128'(sb.size()), 128'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule